// File: doc/BRIEF.md
# Single-Slot Pipeline Buffer with Flush

A one-entry elastic buffer that sits between two pipeline stages. It holds one data word and a valid flag. The upstream stage may write into the slot in the same cycle that the downstream stage takes the current word. As a result, a chain of these buffers advances one word per clock with no bubble between stages.

The space indication (`not_full_o`) is combinational in `deq_i`. A take in the current cycle frees the slot for a write at the same edge, and a stall at the far end of a chain reaches the head in the same cycle. When a take and a write happen together, the take is applied first and the write second. A flush input empties the slot and takes priority over both the take and the write.

Top module: `pipe_fifo1`

## Requirements
- R1: While reset is held and after reset, the slot is empty: `not_empty_o`=0, `not_full_o`=1 (with `deq_i`=0) and `first_o`=0.
- R2: A write (`enq_valid_i`=1, `clear_i`=0) into an empty slot makes `not_empty_o`=1 and `first_o` equal to the written word after the next rising edge.
- R3: `not_full_o` is 1 in the same cycle whenever the slot is empty or `deq_i` is 1, and is 0 otherwise. A write is legal only while `not_full_o`=1, unless `clear_i` is 1 at the same time.
- R4: A write and a take in the same cycle on a full slot leave the slot full, holding the newly written word.
- R5: A take alone (`deq_i`=1, `enq_valid_i`=0) empties the slot at the next edge. A take is legal only while `not_empty_o`=1.
- R6: `clear_i`=1 empties the slot at the next edge whatever the state of `enq_valid_i` and `deq_i`. Afterwards `first_o` reads 0 and no earlier word reappears.
- R7: A full slot with no take and no flush keeps its word and stays full.
- R8: Three buffers chained through their own flags deliver one word per cycle in order when nothing stalls. A stall at the tail drops `not_full_o` at the head in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Flush the slot |
| enq_valid_i | input | 1 | Write the word on enq_data_i |
| enq_data_i | input | DATA_W | Word to write |
| deq_i | input | 1 | Take the word in the slot |
| first_o | output | DATA_W | Stored word, zero when empty |
| not_full_o | output | 1 | Slot can accept a write this cycle |
| not_empty_o | output | 1 | Slot holds a word |

## Verification
The bench drives a write and a take together on a full slot. A design that ordered the write before the take would empty the slot or keep the old word. The bench asserts flush together with a write, a take, or both. A design with the wrong priority would leave a word behind, and one that skips the data wipe would show stale data on `first_o`. The same-cycle space flag is probed right after the inputs change; a registered flag would either lag one cycle or stall a full slot that is being drained. A three-deep chain is streamed and then stalled at its tail. A broken ready path would either insert bubbles or keep accepting at the head while the tail is blocked.

// File: rtl/pipe_fifo1_pkg.sv
package pipe_fifo1_pkg;
  typedef enum logic [1:0] {
    PF1_HOLD  = 2'd0,
    PF1_CLEAR = 2'd1,
    PF1_LOAD  = 2'd2,
    PF1_DRAIN = 2'd3
  } pf1_act_e;
endpackage

// File: rtl/pipe_fifo1_ctrl.sv
module pipe_fifo1_ctrl
  import pipe_fifo1_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  logic     enq_valid_i,
  input  logic     deq_i,
  output pf1_act_e act_o,
  output logic     valid_o,
  output logic     not_full_o
);
  logic valid_q;

  // flush beats write, write (after take) beats take
  always_comb begin
    if (clear_i)          act_o = PF1_CLEAR;
    else if (enq_valid_i) act_o = PF1_LOAD;
    else if (deq_i)       act_o = PF1_DRAIN;
    else                  act_o = PF1_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else begin
      unique case (act_o)
        PF1_CLEAR, PF1_DRAIN: valid_q <= 1'b0;
        PF1_LOAD:             valid_q <= 1'b1;
        default:              valid_q <= valid_q;
      endcase
    end
  end

  assign valid_o    = valid_q;
  assign not_full_o = !valid_q || deq_i;
endmodule

// File: rtl/pipe_fifo1_store.sv
module pipe_fifo1_store
  import pipe_fifo1_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pf1_act_e          act_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] first_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 data_q <= '0;
    else if (act_i == PF1_CLEAR) data_q <= '0;
    else if (act_i == PF1_LOAD)  data_q <= data_i;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign first_o[b] = data_q[b] & valid_i;
  end
endmodule

// File: rtl/pipe_fifo1.sv
module pipe_fifo1
  import pipe_fifo1_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              enq_valid_i,
  input  logic [DATA_W-1:0] enq_data_i,
  input  logic              deq_i,
  output logic [DATA_W-1:0] first_o,
  output logic              not_full_o,
  output logic              not_empty_o
);
  pf1_act_e act;
  logic     valid;

  pipe_fifo1_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .enq_valid_i (enq_valid_i),
    .deq_i       (deq_i),
    .act_o       (act),
    .valid_o     (valid),
    .not_full_o  (not_full_o)
  );

  pipe_fifo1_store #(.DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .valid_i (valid),
    .data_i  (enq_data_i),
    .first_o (first_o)
  );

  assign not_empty_o = valid;
endmodule

// File: rtl/pipe_fifo1_sva.sv
module pipe_fifo1_sva #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              enq_valid_i,
  input logic [DATA_W-1:0] enq_data_i,
  input logic              deq_i,
  input logic [DATA_W-1:0] first_o,
  input logic              not_full_o,
  input logic              not_empty_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_valid_i && !clear_i |-> not_full_o); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> not_empty_o); // R5
  AST_EMPTY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_empty_o |-> not_full_o); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_empty_o |-> first_o == '0); // R1
  AST_LOAD_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_valid_i && !clear_i |=> not_empty_o && first_o == $past(enq_data_i)); // R2
  AST_DRAIN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i && !enq_valid_i && !clear_i |=> !not_empty_o); // R5
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !not_empty_o && first_o == '0); // R6
  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_empty_o && !deq_i && !clear_i && !enq_valid_i |=> not_empty_o && $stable(first_o)); // R7
endmodule

bind pipe_fifo1 pipe_fifo1_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .enq_valid_i (enq_valid_i),
  .enq_data_i  (enq_data_i),
  .deq_i       (deq_i),
  .first_o     (first_o),
  .not_full_o  (not_full_o),
  .not_empty_o (not_empty_o)
);

// File: tb/pipe_fifo1_test.sv
module pipe_fifo1_test;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, enq = 1'b0, deq = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] first;
  logic nf, ne;
  int checks = 0, errors = 0;
  logic [W-1:0] mq[$];

  always #(CLK_P/2) clk = ~clk;

  pipe_fifo1 #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .enq_valid_i(enq),
    .enq_data_i(din), .deq_i(deq), .first_o(first), .not_full_o(nf), .not_empty_o(ne));

  // three-deep chain
  logic src_valid = 1'b0, sink_ready = 1'b0;
  logic [W-1:0] src_data;
  logic [W-1:0] f0, f1, f2;
  logic nf0, nf1, nf2, ne0, ne1, ne2;
  logic e0, e1, e2, d2;
  assign e0 = src_valid && nf0;
  assign e1 = ne0 && nf1;
  assign e2 = ne1 && nf2;
  assign d2 = ne2 && sink_ready;

  pipe_fifo1 #(.DATA_W(W)) c0 (.clk_i(clk), .rst_ni(rst_n), .clear_i(1'b0), .enq_valid_i(e0),
    .enq_data_i(src_data), .deq_i(e1), .first_o(f0), .not_full_o(nf0), .not_empty_o(ne0));
  pipe_fifo1 #(.DATA_W(W)) c1 (.clk_i(clk), .rst_ni(rst_n), .clear_i(1'b0), .enq_valid_i(e1),
    .enq_data_i(f0), .deq_i(e2), .first_o(f1), .not_full_o(nf1), .not_empty_o(ne1));
  pipe_fifo1 #(.DATA_W(W)) c2 (.clk_i(clk), .rst_ni(rst_n), .clear_i(1'b0), .enq_valid_i(e2),
    .enq_data_i(f1), .deq_i(d2), .first_o(f2), .not_full_o(nf2), .not_empty_o(ne2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  src_data <= '0;
    else if (e0) src_data <= src_data + 1'b1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic e, input logic [W-1:0] d, input logic q,
                      input string req);
    @(negedge clk);
    clear = c; enq = e; din = d; deq = q;
    #1;
    chk(req, "not_empty", int'(ne), int'(mq.size() != 0));
    chk(req, "first", int'(first), (mq.size() != 0) ? int'(mq[0]) : 0);
    chk("R3", "not_full", int'(nf), int'(mq.size() == 0 || q));
    @(posedge clk);
    if (c) mq.delete();
    else begin
      if (q && mq.size() != 0) void'(mq.pop_front());
      if (e) mq.push_back(d);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_out;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset not_empty", int'(ne), 0);
    chk("R1", "reset not_full", int'(nf), 1);
    chk("R1", "reset first", int'(first), 0);
    rst_n = 1'b1;

    step(0, 0, 8'h00, 0, "R1");
    step(0, 1, 8'hA5, 0, "R2");
    step(0, 0, 8'h00, 0, "R7");
    step(0, 0, 8'h00, 0, "R7");
    step(0, 0, 8'h00, 1, "R5");
    step(0, 0, 8'h00, 0, "R5");
    step(0, 1, 8'h11, 0, "R2");
    step(0, 1, 8'h22, 1, "R4");
    step(0, 1, 8'h33, 1, "R4");
    step(0, 0, 8'h00, 0, "R4");
    step(1, 1, 8'h44, 0, "R6");
    step(0, 0, 8'h00, 0, "R6");
    step(0, 1, 8'h55, 0, "R2");
    step(1, 0, 8'h00, 1, "R6");
    step(0, 0, 8'h00, 0, "R6");
    step(0, 1, 8'h66, 0, "R2");
    step(1, 1, 8'h77, 1, "R6");
    step(0, 0, 8'h00, 0, "R6");
    step(1, 1, 8'h88, 0, "R6");
    step(0, 1, 8'h99, 0, "R6");
    step(0, 0, 8'h00, 1, "R5");
    step(0, 0, 8'h00, 0, "R5");

    // chain streaming
    @(negedge clk);
    src_valid = 1'b1; sink_ready = 1'b1;
    repeat (3) @(negedge clk);
    exp_out = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      chk("R8", "sink fire", int'(d2), 1);
      chk("R8", "sink data", int'(f2), exp_out);
      exp_out++;
      @(negedge clk);
    end
    sink_ready = 1'b0;
    #1;
    chk("R8", "head blocked on tail stall", int'(nf0), 0);
    chk("R8", "tail full on stall", int'(ne2), 1);
    @(negedge clk);
    #1;
    chk("R8", "held data", int'(f2), exp_out);
    sink_ready = 1'b1;
    #1;
    chk("R8", "head ready on release", int'(nf0), 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #1;
      chk("R8", "sink fire after release", int'(d2), 1);
      chk("R8", "sink data after release", int'(f2), exp_out + i + 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule